// File: doc/BRIEF.md
# Coprocessor Interface Space Decoder

This block sits on an asynchronous, strobe-qualified processor bus and picks out the accesses that the CPU sends to its coprocessor interface registers. These registers live in the CPU-private address space. A cycle qualifies only when the function code marks CPU space and a fixed address nibble names the coprocessor region. The block then reads the coprocessor number and the register offset from the address. If the static presence mask says that coprocessor is fitted, the access goes to a small local register store, one bank of registers per coprocessor, and the block returns a data acknowledge.

A probe of a coprocessor that is not fitted gets no acknowledge. The same holds for any other CPU-space cycle. Such a cycle is left pending until a watchdog, started by the strobe, ends it with a bus error. Software can use this to find out which coprocessors are fitted. The block also drives the select for ordinary memory and peripherals. That select is held off for every CPU-space cycle, so no memory device can answer one.

The bus has no valid/ready stream. A transfer is one strobe-bounded cycle. The master applies back-pressure only by holding the strobe, and the block frees the bus as soon as the strobe drops. Synchronous inputs are assumed: the strobe and the other bus inputs are sampled on the rising clock edge.

Top module: `cir_space_decoder`

## Requirements
- R1: A cycle is a coprocessor-register access only when `bus_fc` is 3'd7 and `bus_addr[19:16]` is 4'b0010. In that case `bus_addr[15:13]` is the coprocessor ID and `bus_addr[4:0]` is the register offset. All other address bits are ignored.
- R2: `mem_select` equals `bus_as` when `bus_fc` is not 7, and is 0 whenever `bus_fc` is 7.
- R3: For a coprocessor access whose ID has its `cp_present` bit set, `bus_dtack` rises at the first rising edge at which `bus_as` is sampled high.
- R4: A write (`bus_rd`=0) to a present coprocessor updates the addressed register. The lanes written follow `bus_size`: 2'b01 writes bits 7:0, 2'b10 writes bits 15:0, and 2'b00 or 2'b11 writes all 32 bits. Unwritten lanes keep their value.
- R5: A read of a present coprocessor puts the addressed register on `bus_rdata` while `bus_dtack` is high. Registers read zero after reset until written. The banks of different IDs are independent, so coprocessor 1 offset 0 (CPU-space address 32'h0002_2000) reads 0 until that register is written.
- R6: A CPU-space cycle that is not acknowledged raises `bus_berr` at exactly the LIMIT-th rising edge (default 64) with `bus_as` held high, and not before. The count restarts when the strobe is negated.
- R7: `bus_dtack` and `bus_berr` are never high together. Both are low after the first rising edge at which `bus_as` is sampled low.
- R8: A cycle with any function code other than 7, including supervisor data (code 5) at 32'h0002_2000, is never acknowledged or errored by this block, however long the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_fc | input | 3 | Function code of the current cycle |
| bus_addr | input | 32 | Cycle address |
| bus_as | input | 1 | Address strobe, active high, held for the whole cycle |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_size | input | 2 | Transfer size: 00 long, 01 byte, 10 word, 11 three-byte (written as long) |
| bus_wdata | input | 32 | Write data, right-aligned |
| cp_present | input | 8 | Static mask, bit n set when coprocessor n is fitted |
| bus_rdata | output | 32 | Read data, valid while bus_dtack is high, else 0 |
| bus_dtack | output | 1 | Data-transfer acknowledge |
| bus_berr | output | 1 | Bus error after watchdog timeout |
| mem_select | output | 1 | Select for ordinary memory/peripherals |

## Verification
The hardest situation to reach from the ports is the exact edge on which the watchdog fires. Reaching it needs a strobe held for the whole timeout on a cycle that nothing answers. The next hardest is telling a function-code-5 access at the coprocessor address apart from a real probe. The bench holds the strobe and counts edges until a response appears. It expects the count to be exactly the limit for unanswered CPU-space cycles, and to run past the limit with no response for other function codes. The random address mix covers IDs that are fitted and IDs that are absent, region nibbles that match and ones that do not, and a narrow range of offsets, so that byte and word writes merge into registers written earlier.

// File: rtl/cir_pkg.sv
package cir_pkg;
  localparam logic [2:0] FC_CPU_SPACE = 3'd7;
  localparam logic [3:0] CIR_REGION   = 4'b0010;
  localparam int         REGION_LSB   = 16;
  localparam int         CPID_LSB     = 13;

  typedef enum logic [1:0] {
    SZ_LONG   = 2'b00,
    SZ_BYTE   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_TRIPLE = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/cir_decode.sv
module cir_decode #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 3,
  parameter int OFS_W  = 5
) (
  input  logic [2:0]        fc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_i,
  output logic              cpu_space,
  output logic              cir_hit,
  output logic [ID_W-1:0]   cp_id,
  output logic [OFS_W-1:0]  cir_ofs,
  output logic              mem_sel
);
  import cir_pkg::*;

  logic [3:0] region;
  logic       unused_addr_bits;

  assign region    = addr[REGION_LSB +: 4];
  assign cpu_space = (fc == FC_CPU_SPACE);
  assign cir_hit   = cpu_space && (region == CIR_REGION);
  assign cp_id     = addr[CPID_LSB +: ID_W];
  assign cir_ofs   = addr[OFS_W-1:0];
  // ordinary decoders never see CPU-space cycles
  assign mem_sel   = as_i && !cpu_space;

  assign unused_addr_bits = ^{addr[ADDR_W-1:REGION_LSB+4], addr[CPID_LSB-1:OFS_W]};
endmodule

// File: rtl/cir_regfile.sv
module cir_regfile #(
  parameter int NUM_CP   = 8,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ID_W    = $clog2(NUM_CP),
  localparam int OFS_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   cp_id,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import cir_pkg::*;

  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] bank_rd [NUM_CP];

  always_comb begin
    case (xfer_size_e'(size))
      SZ_BYTE: lane_mask = {{(DATA_W-8){1'b0}}, 8'hFF};
      SZ_WORD: lane_mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: lane_mask = '1;
    endcase
  end

  for (genvar g = 0; g < NUM_CP; g++) begin : g_bank
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              bank_we;

    assign bank_we    = wr_en && (cp_id == ID_W'(g));
    assign bank_rd[g] = regs[ofs];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (bank_we) begin
        regs[ofs] <= (regs[ofs] & ~lane_mask) | (wdata & lane_mask);
      end
    end
  end

  assign rdata = bank_rd[cp_id];
endmodule

// File: rtl/cir_bus_timer.sv
module cir_bus_timer #(
  parameter int LIMIT = 64,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_i,
  input  logic arm,
  output logic expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!as_i) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (arm && !expired) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(LIMIT - 1)) expired <= 1'b1;
    end
  end
endmodule

// File: rtl/cir_space_decoder.sv
module cir_space_decoder #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_CP    = 8,
  parameter int NUM_REGS  = 32,
  parameter int BERR_LIMIT = 64,
  localparam int ID_W     = $clog2(NUM_CP),
  localparam int OFS_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_fc,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_as,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NUM_CP-1:0] cp_present,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_dtack,
  output logic              bus_berr,
  output logic              mem_select
);
  logic              cpu_space, cir_hit, fitted, ack_now, wr_en, arm;
  logic [ID_W-1:0]   cp_id;
  logic [OFS_W-1:0]  cir_ofs;
  logic [DATA_W-1:0] rf_rdata, rdata_q;
  logic              dtack_q;

  cir_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W), .OFS_W(OFS_W)) u_dec (
    .fc(bus_fc), .addr(bus_addr), .as_i(bus_as),
    .cpu_space(cpu_space), .cir_hit(cir_hit), .cp_id(cp_id),
    .cir_ofs(cir_ofs), .mem_sel(mem_select)
  );

  assign fitted  = cp_present[cp_id];
  assign ack_now = bus_as && cir_hit && fitted && !dtack_q;
  assign wr_en   = ack_now && !bus_rd;
  assign arm     = bus_as && cpu_space && !(cir_hit && fitted);

  cir_regfile #(.NUM_CP(NUM_CP), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cp_id(cp_id), .ofs(cir_ofs),
    .size(bus_size), .wdata(bus_wdata), .rdata(rf_rdata)
  );

  cir_bus_timer #(.LIMIT(BERR_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .as_i(bus_as), .arm(arm), .expired(bus_berr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtack_q <= 1'b0;
      rdata_q <= '0;
    end else if (!bus_as) begin
      dtack_q <= 1'b0;
      rdata_q <= '0;
    end else if (ack_now) begin
      dtack_q <= 1'b1;
      rdata_q <= bus_rd ? rf_rdata : '0;
    end
  end

  assign bus_dtack = dtack_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/cir_space_decoder_sva.sv
module cir_space_decoder_sva #(
  parameter int ADDR_W     = 32,
  parameter int NUM_CP     = 8,
  parameter int BERR_LIMIT = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_fc,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_as,
  input logic [NUM_CP-1:0] cp_present,
  input logic              bus_dtack,
  input logic              bus_berr,
  input logic              mem_select
);
  localparam int CW = $clog2(BERR_LIMIT + 2);
  logic [CW-1:0] as_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          as_cnt <= '0;
    else if (!bus_as)                    as_cnt <= '0;
    else if (as_cnt < CW'(BERR_LIMIT+1)) as_cnt <= as_cnt + 1'b1;
  end

  p_cpu_space_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_fc == 3'd7 && bus_addr[19:16] == 4'b0010 &&
     cp_present[bus_addr[15:13]] && !bus_dtack) |=> bus_dtack);

  p_no_mem_in_cpu_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fc == 3'd7) |-> !mem_select);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_dtack && bus_berr));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as |=> (!bus_dtack && !bus_berr));

  p_ack_only_cpu_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_dtack) |-> $past(bus_fc) == 3'd7);

  p_berr_at_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_berr) |-> as_cnt == CW'(BERR_LIMIT));
endmodule

bind cir_space_decoder cir_space_decoder_sva #(
  .ADDR_W(ADDR_W), .NUM_CP(NUM_CP), .BERR_LIMIT(BERR_LIMIT)
) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_fc(bus_fc), .bus_addr(bus_addr),
  .bus_as(bus_as), .cp_present(cp_present), .bus_dtack(bus_dtack),
  .bus_berr(bus_berr), .mem_select(mem_select)
);

// File: tb/cir_space_decoder_tb.sv
module cir_space_decoder_tb;
  localparam int LIMIT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_fc = '0;
  logic [31:0] bus_addr = '0;
  logic        bus_as = 1'b0;
  logic        bus_rd = 1'b1;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  cp_present = 8'b1010_0011;
  logic [31:0] bus_rdata;
  logic        bus_dtack, bus_berr, mem_select;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8][32];

  always #2 clk = ~clk;

  cir_space_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_fc(bus_fc), .bus_addr(bus_addr),
    .bus_as(bus_as), .bus_rd(bus_rd), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .cp_present(cp_present), .bus_rdata(bus_rdata),
    .bus_dtack(bus_dtack), .bus_berr(bus_berr), .mem_select(mem_select)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 = memory cycle, 1 = acknowledged, 2 = bus error
  function automatic int kind_of(input logic [2:0] fc, input logic [31:0] a);
    if (fc != 3'd7) return 0;
    if (a[19:16] == 4'b0010 && cp_present[a[15:13]]) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [1:0] sz);
    logic [31:0] m;
    m = (sz == 2'b01) ? 32'h0000_00FF : (sz == 2'b10) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    return (old & ~m) | (wd & m);
  endfunction

  task automatic run_cycle(input logic [2:0] fc, input logic [31:0] a, input bit rd,
                           input logic [1:0] sz, input logic [31:0] wd);
    int n, k;
    logic [31:0] expd;
    k = kind_of(fc, a);
    @(negedge clk);
    bus_fc = fc; bus_addr = a; bus_rd = rd; bus_size = sz; bus_wdata = wd;
    bus_as = 1'b1;
    #0.5;
    check(mem_select == (fc != 3'd7), "R2 mem_select", 32'(mem_select), 32'(fc != 3'd7));
    n = 0;
    while (!(bus_dtack || bus_berr) && n < LIMIT + 4) begin
      @(posedge clk); @(negedge clk); n++;
    end
    if (k == 1) begin
      check(bus_dtack && n == 1, "R1/R3 ack edge", 32'(n), 32'd1);
      if (rd) begin
        expd = model[a[15:13]][a[4:0]];
        check(bus_rdata == expd, "R5 read data", bus_rdata, expd);
      end else begin
        model[a[15:13]][a[4:0]] = merge(model[a[15:13]][a[4:0]], wd, sz);
      end
    end else if (k == 2) begin
      check(bus_berr && !bus_dtack && n == LIMIT, "R1/R6 berr edge", 32'(n), 32'(LIMIT));
    end else begin
      check(!bus_berr && !bus_dtack && n == LIMIT + 4, "R8 no response", 32'(n),
            32'(LIMIT + 4));
    end
    bus_as = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!bus_dtack && !bus_berr, "R7 release", {30'd0, bus_dtack, bus_berr}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0]  fc;
    logic [31:0] a;
    int r;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 32; j++) model[i][j] = '0;
    void'($urandom(32'd2718));
    #10 rst_n = 1'b1;
    @(negedge clk);
    check(!bus_dtack && !bus_berr && !mem_select && bus_rdata == 0, "R7 reset state",
          bus_rdata, 32'd0);

    // directed corners
    run_cycle(3'd7, 32'h0002_2000, 1'b1, 2'b00, '0);            // R5 unwritten reads zero
    run_cycle(3'd5, 32'h0002_2000, 1'b0, 2'b00, 32'hDEAD_BEEF); // R8 supervisor data
    run_cycle(3'd7, 32'h0002_2000, 1'b1, 2'b00, '0);            // R8 no write leaked
    run_cycle(3'd7, 32'h0002_4000, 1'b1, 2'b00, '0);            // R6 absent ID 2
    run_cycle(3'd7, 32'h0004_2000, 1'b1, 2'b00, '0);            // R1 wrong region nibble
    run_cycle(3'd7, 32'h0002_2003, 1'b0, 2'b00, 32'h1122_3344); // R4 long
    run_cycle(3'd7, 32'h0002_2003, 1'b0, 2'b01, 32'hFFFF_FFAA); // R4 byte
    run_cycle(3'd7, 32'h0002_2003, 1'b0, 2'b10, 32'hFFFF_BBCC); // R4 word
    run_cycle(3'd7, 32'h0002_2003, 1'b1, 2'b00, '0);            // R4 merged value
    run_cycle(3'd7, 32'h0002_0003, 1'b0, 2'b11, 32'h5555_AAAA); // R5 other bank
    run_cycle(3'd7, 32'hFFF2_3FE3, 1'b1, 2'b00, '0);            // R1 ignored bits
    run_cycle(3'd7, 32'h0002_0003, 1'b1, 2'b00, '0);

    // constrained random
    for (int i = 0; i < 250; i++) begin
      r = $urandom % 8;
      fc = (r < 6) ? 3'd7 : 3'(($urandom % 7));
      a = $urandom;
      if ($urandom % 8 != 0) a[19:16] = 4'b0010;
      if ($urandom % 2 == 0) a[4:0] = 5'($urandom % 4);
      run_cycle(fc, a, 1'($urandom % 2), 2'($urandom % 4), $urandom);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule